// File: doc/BRIEF.md
# Smart card serial status and interrupt controller

This block sits beside a byte-level serial engine that runs in smart card mode. The engine reports five kinds of one-cycle events: a byte has finished transmitting, a byte has been received, the byte had a parity error, a new byte arrived while the previous one was still unread, and the card signalled an error. From these events the block keeps a set of sticky status flags and holds the last accepted receive byte. It drives three level interrupt lines, for transmit, receive and error. It also issues one-cycle data-move trigger strobes that a DMA engine can use.

The block also owns the transmit-enable and receive-enable bits. It refuses an enable request that would switch direction before the operation in the other direction has finished. Software or a register decoder clears flags with one strobe per flag. Enables are written with write strobes that carry a value.

Top module: `sc_irq_ctrl`

## Requirements
- R1: `txi_o` equals transmit-end AND `tie_i`, `rxi_o` equals receive-full AND `rie_i`, and `eri_o` equals (overrun OR parity OR card-error) AND `rie_i`. Each is registered, so it follows the flag and enable values by one clock.
- R2: A transmit-end event sets both the transmit-empty and the transmit-end flags at the same clock edge.
- R3: A receive event that arrives while receive-full is clear stores `rx_data_i` in `rx_data_o` and sets receive-full. If `par_err_ev_i` is high at the same time, the parity flag is also set and the byte is still stored.
- R4: A receive event that arrives while receive-full is set sets the overrun flag. It leaves `rx_data_o` unchanged and does not set the parity flag.
- R5: Flags are sticky until their clear strobe, and a set event in the same cycle wins over the clear. The bit positions in `flags_o` and `clr_i` are: 0 transmit-empty, 1 transmit-end, 2 receive-full, 3 overrun, 4 parity, 5 card-error. Reset value is 6'b000011.
- R6: `dma_tx_o` and `dma_rx_o` are single-cycle pulses in the cycle where `txi_o` or `rxi_o` rises. The error interrupt never produces a strobe.
- R7: A request to turn the receiver on is accepted only when the transmitter is off and the transmit-end flag is set.
- R8: A request to turn the transmitter on is accepted only when the receiver is off and any reception started since the last receiver enable has ended. A reception has ended once receive-full, parity or overrun is set.
- R9: Turning an enable off is always accepted. Requests to turn both on in the same cycle are both rejected. `te_o` and `re_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_end_ev_i | input | 1 | Byte transmission complete pulse |
| rx_done_ev_i | input | 1 | Byte reception complete pulse |
| par_err_ev_i | input | 1 | Parity error, qualifies rx_done_ev_i |
| err_sig_ev_i | input | 1 | Card error signal detected pulse |
| rx_data_i | input | DW | Received byte from the engine |
| clr_i | input | 6 | Per-flag clear strobes |
| te_wr_i | input | 1 | Transmit enable write strobe |
| te_val_i | input | 1 | Transmit enable write value |
| re_wr_i | input | 1 | Receive enable write strobe |
| re_val_i | input | 1 | Receive enable write value |
| tie_i | input | 1 | Transmit interrupt enable |
| rie_i | input | 1 | Receive and error interrupt enable |
| flags_o | output | 6 | Status flags |
| rx_data_o | output | DW | Receive data register |
| te_o | output | 1 | Transmitter enabled |
| re_o | output | 1 | Receiver enabled |
| txi_o | output | 1 | Transmit interrupt |
| rxi_o | output | 1 | Receive interrupt |
| eri_o | output | 1 | Error interrupt |
| dma_tx_o | output | 1 | Transmit data-move trigger |
| dma_rx_o | output | 1 | Receive data-move trigger |

## Verification
The bench builds the block with the default 8-bit data width. The flag set is only six bits and there are only two interrupt enables, so every combination of the two enables can be crossed with every event kind. The bench predicts all flags, interrupts and strobes from that pairing. Directed sequences then cover overrun, set-versus-clear collisions, and every accept and reject path of the direction-switch guard.

// File: rtl/sc_irq_pkg.sv
package sc_irq_pkg;
  localparam int NFLAG  = 6;
  localparam int F_TDRE = 0;
  localparam int F_TEND = 1;
  localparam int F_RDRF = 2;
  localparam int F_ORER = 3;
  localparam int F_PER  = 4;
  localparam int F_ERS  = 5;
  typedef logic [NFLAG-1:0] flag_vec_t;
  localparam flag_vec_t FLAG_RST = flag_vec_t'(6'b000011);
endpackage

// File: rtl/sc_flag_bank.sv
module sc_flag_bank
  import sc_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_end_ev_i,
  input  logic          rx_done_ev_i,
  input  logic          par_err_ev_i,
  input  logic          err_sig_ev_i,
  input  logic [DW-1:0] rx_data_i,
  input  flag_vec_t     clr_i,
  output flag_vec_t     flags_o,
  output logic [DW-1:0] rx_data_o
);
  flag_vec_t     flag_q, set_v;
  logic [DW-1:0] data_q;

  always_comb begin
    set_v         = '0;
    set_v[F_TDRE] = tx_end_ev_i;
    set_v[F_TEND] = tx_end_ev_i;
    set_v[F_RDRF] = rx_done_ev_i & ~flag_q[F_RDRF];
    set_v[F_ORER] = rx_done_ev_i &  flag_q[F_RDRF];
    set_v[F_PER]  = rx_done_ev_i & ~flag_q[F_RDRF] & par_err_ev_i;
    set_v[F_ERS]  = err_sig_ev_i;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= FLAG_RST[i];
      else         flag_q[i] <= set_v[i] | (flag_q[i] & ~clr_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             data_q <= '0;
    else if (set_v[F_RDRF])  data_q <= rx_data_i;
  end

  assign flags_o   = flag_q;
  assign rx_data_o = data_q;

  // R2
  tx_end_sets_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_end_ev_i |=> (flags_o[F_TDRE] && flags_o[F_TEND]));
  // R4
  overrun_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_ev_i && flags_o[F_RDRF]) |=> (flags_o[F_ORER] && $stable(rx_data_o)));
  // R3
  rx_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_ev_i && !flags_o[F_RDRF]) |=> (rx_data_o == $past(rx_data_i) && flags_o[F_RDRF]));
endmodule

// File: rtl/sc_mode_guard.sv
module sc_mode_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic te_wr_i,
  input  logic te_val_i,
  input  logic re_wr_i,
  input  logic re_val_i,
  input  logic tend_i,
  input  logic rx_fin_i,
  output logic te_o,
  output logic re_o
);
  logic te_q, re_q, rx_pend_q;
  logic te_on_req, re_on_req, te_ok, re_ok, rx_open;

  assign te_on_req = te_wr_i & te_val_i;
  assign re_on_req = re_wr_i & re_val_i;
  // reception counts as finished as soon as a completion flag is visible
  assign rx_open   = rx_pend_q & ~rx_fin_i;
  assign te_ok     = te_on_req & ~re_on_req & ~re_q & ~rx_open;
  assign re_ok     = re_on_req & ~te_on_req & ~te_q & ~re_q & tend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      te_q      <= 1'b0;
      re_q      <= 1'b0;
      rx_pend_q <= 1'b0;
    end else begin
      if (te_wr_i) te_q <= te_val_i & (te_q | te_ok);
      if (re_wr_i) re_q <= re_val_i & (re_q | re_ok);
      if (re_ok)         rx_pend_q <= 1'b1;
      else if (rx_fin_i) rx_pend_q <= 1'b0;
    end
  end

  assign te_o = te_q;
  assign re_o = re_q;

  // R9
  never_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(te_o && re_o));
  // R7
  re_needs_tend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(re_o) |-> ($past(tend_i) && !$past(te_o)));
  // R8
  te_needs_rx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(te_o) |-> !$past(re_o));
endmodule

// File: rtl/sc_irq_out.sv
module sc_irq_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tend_i,
  input  logic rdrf_i,
  input  logic err_any_i,
  input  logic tie_i,
  input  logic rie_i,
  output logic txi_o,
  output logic rxi_o,
  output logic eri_o,
  output logic dma_tx_o,
  output logic dma_rx_o
);
  logic txi_d, rxi_d;

  assign txi_d = tend_i & tie_i;
  assign rxi_d = rdrf_i & rie_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txi_o    <= 1'b0;
      rxi_o    <= 1'b0;
      eri_o    <= 1'b0;
      dma_tx_o <= 1'b0;
      dma_rx_o <= 1'b0;
    end else begin
      txi_o    <= txi_d;
      rxi_o    <= rxi_d;
      eri_o    <= err_any_i & rie_i;
      dma_tx_o <= txi_d & ~txi_o;
      dma_rx_o <= rxi_d & ~rxi_o;
    end
  end

  // R1
  eri_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eri_o |-> ($past(rie_i) && $past(err_any_i)));
  // R6
  dma_tx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_tx_o |=> !dma_tx_o);
  // R6
  dma_rx_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_rx_o |-> ($past(rdrf_i) && $past(rie_i)));
endmodule

// File: rtl/sc_irq_ctrl.sv
module sc_irq_ctrl
  import sc_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_end_ev_i,
  input  logic          rx_done_ev_i,
  input  logic          par_err_ev_i,
  input  logic          err_sig_ev_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic [5:0]    clr_i,
  input  logic          te_wr_i,
  input  logic          te_val_i,
  input  logic          re_wr_i,
  input  logic          re_val_i,
  input  logic          tie_i,
  input  logic          rie_i,
  output logic [5:0]    flags_o,
  output logic [DW-1:0] rx_data_o,
  output logic          te_o,
  output logic          re_o,
  output logic          txi_o,
  output logic          rxi_o,
  output logic          eri_o,
  output logic          dma_tx_o,
  output logic          dma_rx_o
);
  flag_vec_t flags;

  sc_flag_bank #(.DW(DW)) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_end_ev_i  (tx_end_ev_i),
    .rx_done_ev_i (rx_done_ev_i),
    .par_err_ev_i (par_err_ev_i),
    .err_sig_ev_i (err_sig_ev_i),
    .rx_data_i    (rx_data_i),
    .clr_i        (flag_vec_t'(clr_i)),
    .flags_o      (flags),
    .rx_data_o    (rx_data_o)
  );

  sc_mode_guard u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .te_wr_i  (te_wr_i),
    .te_val_i (te_val_i),
    .re_wr_i  (re_wr_i),
    .re_val_i (re_val_i),
    .tend_i   (flags[F_TEND]),
    .rx_fin_i (flags[F_RDRF] | flags[F_PER] | flags[F_ORER]),
    .te_o     (te_o),
    .re_o     (re_o)
  );

  sc_irq_out u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tend_i    (flags[F_TEND]),
    .rdrf_i    (flags[F_RDRF]),
    .err_any_i (flags[F_ORER] | flags[F_PER] | flags[F_ERS]),
    .tie_i     (tie_i),
    .rie_i     (rie_i),
    .txi_o     (txi_o),
    .rxi_o     (rxi_o),
    .eri_o     (eri_o),
    .dma_tx_o  (dma_tx_o),
    .dma_rx_o  (dma_rx_o)
  );

  assign flags_o = flags;
endmodule

// File: tb/sc_irq_ctrl_test.sv
module sc_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tx_end = 0, rx_done = 0, par_err = 0, err_sig = 0;
  logic [7:0] rx_data = '0;
  logic [5:0] clr = '0;
  logic te_wr = 0, te_val = 0, re_wr = 0, re_val = 0, tie = 0, rie = 0;
  logic [5:0] flags;
  logic [7:0] rxd;
  logic te, re, txi, rxi, eri, dtx, drx;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_irq_ctrl #(.DW(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tx_end_ev_i(tx_end), .rx_done_ev_i(rx_done),
    .par_err_ev_i(par_err), .err_sig_ev_i(err_sig), .rx_data_i(rx_data), .clr_i(clr),
    .te_wr_i(te_wr), .te_val_i(te_val), .re_wr_i(re_wr), .re_val_i(re_val),
    .tie_i(tie), .rie_i(rie), .flags_o(flags), .rx_data_o(rxd), .te_o(te), .re_o(re),
    .txi_o(txi), .rxi_o(rxi), .eri_o(eri), .dma_tx_o(dtx), .dma_rx_o(drx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic clear_all();
    clr = '1; @(negedge clk); clr = '0; @(negedge clk);
  endtask

  task automatic wr_en(input logic tw, input logic tv, input logic rw, input logic rv);
    te_wr = tw; te_val = tv; re_wr = rw; re_val = rv;
    @(negedge clk);
    te_wr = 0; te_val = 0; re_wr = 0; re_val = 0;
  endtask

  task automatic pulse_rx(input logic [7:0] d, input logic pe);
    rx_done = 1; par_err = pe; rx_data = d;
    @(negedge clk);
    rx_done = 0; par_err = 0;
  endtask

  task automatic pulse_tx();
    tx_end = 1; @(negedge clk); tx_end = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [5:0] ef;
    logic et, er, ee;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R5 reset state
    chk("R5 reset flags", flags, 6'b000011);
    chk("R9 reset enables", {te, re}, 2'b00);
    chk("R1 reset irqs", {txi, rxi, eri, dtx, drx}, 5'b0);

    // R1 R2 R3 R6: all enable pairs against every event kind
    for (int m = 0; m < 4; m++) begin
      for (int ev = 0; ev < 4; ev++) begin
        tie = 0; rie = 0;
        clear_all();
        @(negedge clk);
        tie = m[0]; rie = m[1];
        @(negedge clk);
        rx_data = 8'(8'h30 + 4 * m + ev);
        tx_end = (ev == 0); rx_done = (ev == 1 || ev == 2);
        par_err = (ev == 2); err_sig = (ev == 3);
        @(negedge clk);
        tx_end = 0; rx_done = 0; par_err = 0; err_sig = 0;
        case (ev)
          0: ef = 6'b000011;
          1: ef = 6'b000100;
          2: ef = 6'b010100;
          default: ef = 6'b100000;
        endcase
        chk("R2 R3 flags after event", flags, ef);
        if (ev == 1 || ev == 2) chk("R3 byte stored", rxd, 8'(8'h30 + 4 * m + ev));
        et = (ev == 0) & m[0];
        er = (ev == 1 || ev == 2) & m[1];
        ee = (ev == 2 || ev == 3) & m[1];
        @(negedge clk);
        chk("R1 irq levels", {txi, rxi, eri}, {et, er, ee});
        chk("R6 strobes", {dtx, drx}, {et, er});
        @(negedge clk);
        chk("R6 strobe single cycle", {dtx, drx}, 2'b00);
        chk("R1 irq held", {txi, rxi, eri}, {et, er, ee});
      end
    end

    // R4 overrun
    tie = 0; rie = 1;
    clear_all();
    pulse_rx(8'hA5, 1'b0);
    pulse_rx(8'h5A, 1'b1);
    chk("R4 overrun flags", flags, 6'b001100);
    chk("R4 data kept", rxd, 8'hA5);
    @(negedge clk);
    chk("R4 eri from overrun", {rxi, eri}, 2'b11);
    chk("R6 no strobe from error", {dtx, drx}, 2'b00);

    // R5 set wins over clear, plain clear works
    rie = 0;
    clear_all();
    err_sig = 1; @(negedge clk); err_sig = 0;
    err_sig = 1; clr = 6'b100000; tx_end = 1;
    @(negedge clk);
    err_sig = 0; tx_end = 0; clr = 6'b000010;
    @(negedge clk);
    clr = 0;
    chk("R5 set wins then tend cleared", flags, 6'b100001);
    clr = 6'b100000; @(negedge clk); clr = 0;
    chk("R5 plain clear", flags, 6'b000001);

    // R7 R8 R9 direction switching
    clear_all();
    tx_end = 1; @(negedge clk); tx_end = 0;
    wr_en(1, 1, 0, 0);
    chk("R8 te on from idle", te, 1'b1);
    wr_en(0, 0, 1, 1);
    chk("R7 re rejected while te on", re, 1'b0);
    clr = 6'b000010; @(negedge clk); clr = 0;
    wr_en(1, 0, 0, 0);
    chk("R9 te off accepted", te, 1'b0);
    wr_en(0, 0, 1, 1);
    chk("R7 re rejected without tend", re, 1'b0);
    pulse_tx();
    wr_en(0, 0, 1, 1);
    chk("R7 re accepted after tend", re, 1'b1);
    wr_en(1, 1, 0, 0);
    chk("R8 te rejected while re on", te, 1'b0);
    wr_en(0, 0, 1, 0);
    chk("R9 re off accepted", re, 1'b0);
    wr_en(1, 1, 0, 0);
    chk("R8 te rejected before rx end", te, 1'b0);
    pulse_rx(8'h11, 1'b0);
    wr_en(1, 1, 0, 0);
    chk("R8 te accepted after rx end", te, 1'b1);
    wr_en(1, 0, 0, 0);
    wr_en(1, 1, 1, 1);
    chk("R9 simultaneous on rejected", {te, re}, 2'b00);

    finish_run();
  end
endmodule